// File: doc/BRIEF.md
# Per-Bit Access-Mode Register Bank

This block is a bank of control and status registers that a processor reaches over a simple synchronous bus, while the surrounding logic loads and observes the same registers directly. Each register sits at an address taken from a per-register table. The table may leave gaps and need not be in order. Every single bit carries its own access mode, set at elaboration time, so one register can mix read/write, read-only, clear-on-read, write-only, live pass-through and unused bits.

The logic side loads a whole register by pulsing that register's update enable with a data word. It feeds pass-through bits through a live input vector. It reads every register at once from a flat export vector, where register i occupies bits [i*DATA_W +: DATA_W]. Bits in a mode with no storage cost no flip-flop.

Mode codes are 3 bits per register bit. They are packed in `MODE_TABLE` at index `(i*DATA_W+b)*3`. Addresses are packed in `ADDR_TABLE` at `i*ADDR_W`. The default configuration has six 8-bit registers at addresses 0, 3, 4, 9, 10 and 16.

Top module: `acc_regbank`

## Requirements
- R1: A synchronous active-high `rst` clears every stored bit and `cpu_rdata` to zero.
- R2: A register responds only at its address from `ADDR_TABLE`. A read of an address not in the table returns zero, and a write to such an address changes no register.
- R3: Mode code 1 (read/write): a CPU write at the register's address stores the write-data bit, and a CPU read returns the stored bit.
- R4: Mode code 2 (clear-on-read): a CPU write has no effect. A CPU read returns the stored bit and leaves it zero after that edge.
- R5: Mode code 3 (read-only): a CPU write leaves the bit unchanged, and a CPU read returns the stored bit.
- R6: Mode code 4 (write-only): a CPU write stores the bit, which appears on `regs_out`. A CPU read returns zero.
- R7: Mode code 5 (pass-through): there is no storage. Both `regs_out` and a CPU read show the `live_in` bit as sampled at that edge.
- R8: Mode code 0 (unused): a CPU read returns zero, `regs_out` shows zero, and neither a CPU write nor an update has any effect.
- R9: When `upd_en[i]` is high on an edge, every stored bit of register i loads from `upd_data`. This takes priority over a CPU write and over a clear-on-read in the same cycle.
- R10: `cpu_rdata` changes only on an edge where `cpu_rd` is high, and is valid one cycle after the read strobe. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | DATA_W | Registered CPU read data |
| upd_en | input | NUM_REGS | Per-register logic-side load enable |
| upd_data | input | NUM_REGS*DATA_W | Logic-side load words, one per register |
| live_in | input | NUM_REGS*DATA_W | Live values for pass-through bits |
| regs_out | output | NUM_REGS*DATA_W | Current value of every register, concatenated |

## Verification
The assertions assume that the addresses in the table are distinct, so that at most one register decodes any bus address. They also assume that the strobes and update enables are never unknown after reset. The bench uses only the default table, which has unique addresses. It sweeps every address of the 5-bit space, holes included. It drives all strobes and enables to defined levels from time zero.

// File: rtl/acc_regbank.sv
module acc_regbank #(
  parameter int NUM_REGS = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [NUM_REGS*ADDR_W-1:0] ADDR_TABLE =
    {5'd16, 5'd10, 5'd9, 5'd4, 5'd3, 5'd0},
  parameter logic [NUM_REGS*DATA_W*3-1:0] MODE_TABLE =
    {24'hB6DB6D, 24'hA00249, 24'h249249, 24'h924924, 24'h4926DB, 24'h249249}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  input  logic                       cpu_wr,
  input  logic                       cpu_rd,
  output logic [DATA_W-1:0]          cpu_rdata,
  input  logic [NUM_REGS-1:0]        upd_en,
  input  logic [NUM_REGS*DATA_W-1:0] upd_data,
  input  logic [NUM_REGS*DATA_W-1:0] live_in,
  output logic [NUM_REGS*DATA_W-1:0] regs_out
);
  localparam int VEC_W = NUM_REGS*DATA_W;
  localparam logic [2:0] MD_UNUSED = 3'd0;
  localparam logic [2:0] MD_RW     = 3'd1;
  localparam logic [2:0] MD_COR    = 3'd2;
  localparam logic [2:0] MD_RO     = 3'd3;
  localparam logic [2:0] MD_WO     = 3'd4;
  localparam logic [2:0] MD_PASS   = 3'd5;

  logic [NUM_REGS-1:0] hit;
  logic [VEC_W-1:0]    rd_view;
  logic [DATA_W-1:0]   rd_mux;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit[i] = (cpu_addr == ADDR_TABLE[i*ADDR_W +: ADDR_W]);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int K = i*DATA_W + b;
      localparam logic [2:0] M = MODE_TABLE[K*3 +: 3];
      localparam bit CPU_WE = (M == MD_RW) || (M == MD_WO);
      localparam bit CLR_RD = (M == MD_COR);

      if (M == MD_RW || M == MD_COR || M == MD_RO || M == MD_WO) begin : g_st
        logic q;
        logic unused_live;
        assign unused_live = live_in[K];

        always_ff @(posedge clk) begin
          if (rst)                              q <= 1'b0;
          else if (upd_en[i])                   q <= upd_data[K];
          else if (CPU_WE && cpu_wr && hit[i])  q <= cpu_wdata[b];
          else if (CLR_RD && cpu_rd && hit[i])  q <= 1'b0;
        end

        assign regs_out[K] = q;
        assign rd_view[K]  = (M == MD_WO) ? 1'b0 : q;

        AST_UPD_LOADS: assert property (@(posedge clk) disable iff (rst)
          upd_en[i] |=> (q == $past(upd_data[K]))); // R9

        if (M == MD_RW) begin : g_rw_chk
          AST_RW_WRITES: assert property (@(posedge clk) disable iff (rst)
            (cpu_wr && hit[i] && !upd_en[i]) |=> (q == $past(cpu_wdata[b]))); // R3
        end
        if (M == MD_RO) begin : g_ro_chk
          AST_RO_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (cpu_wr && hit[i] && !upd_en[i]) |=> $stable(q)); // R5
        end
        if (M == MD_COR) begin : g_cor_chk
          AST_COR_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (cpu_rd && hit[i] && !upd_en[i]) |=> !q); // R4
        end
      end else if (M == MD_PASS) begin : g_pass
        logic unused_upd;
        assign unused_upd   = upd_data[K];
        assign regs_out[K]  = live_in[K];
        assign rd_view[K]   = live_in[K];
      end else begin : g_none
        logic unused_both;
        assign unused_both  = upd_data[K] ^ live_in[K];
        assign regs_out[K]  = 1'b0;
        assign rd_view[K]   = 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) rd_mux = rd_mux | rd_view[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= rd_mux;
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && (hit == '0)) |=> (cpu_rdata == '0)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata)); // R10
endmodule

// File: tb/acc_regbank_tb.sv
`timescale 1ns/1ps
module acc_regbank_tb_top;
  localparam int NR = 6;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int VW = NR*DW;
  localparam logic [NR*AW-1:0] ADDRS = {5'd16, 5'd10, 5'd9, 5'd4, 5'd3, 5'd0};
  localparam logic [NR*DW*3-1:0] MODES =
    {24'hB6DB6D, 24'hA00249, 24'h249249, 24'h924924, 24'h4926DB, 24'h249249};

  logic clk = 0;
  logic rst = 1;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [DW-1:0] cpu_rdata;
  logic [NR-1:0] upd_en = '0;
  logic [VW-1:0] upd_data = '0, live_in = '0, regs_out;

  acc_regbank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW),
                .ADDR_TABLE(ADDRS), .MODE_TABLE(MODES)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .upd_en(upd_en), .upd_data(upd_data), .live_in(live_in), .regs_out(regs_out));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] st [NR];
  logic [DW-1:0] exp_rd = '0;

  function automatic logic [2:0] mode_of(int i, int b);
    return MODES[(i*DW+b)*3 +: 3];
  endfunction

  function automatic logic [VW-1:0] exp_out();
    logic [VW-1:0] v = '0;
    for (int i = 0; i < NR; i++)
      for (int b = 0; b < DW; b++)
        case (mode_of(i, b))
          3'd1, 3'd2, 3'd3, 3'd4: v[i*DW+b] = st[i][b];
          3'd5: v[i*DW+b] = live_in[i*DW+b];
          default: v[i*DW+b] = 1'b0;
        endcase
    return v;
  endfunction

  function automatic logic [DW-1:0] read_of(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NR; i++)
      if (ADDRS[i*AW +: AW] == a)
        for (int b = 0; b < DW; b++)
          case (mode_of(i, b))
            3'd1, 3'd2, 3'd3: r[b] = st[i][b];
            3'd5: r[b] = live_in[i*DW+b];
            default: r[b] = 1'b0;
          endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr, bit rd, logic [AW-1:0] a,
                      logic [DW-1:0] wd, logic [NR-1:0] ue, logic [VW-1:0] ud);
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = wd;
    upd_en = ue; upd_data = ud;
    #1;
    if (rd) exp_rd = read_of(a);
    for (int i = 0; i < NR; i++)
      for (int b = 0; b < DW; b++) begin
        logic [2:0] m = mode_of(i, b);
        bit h = (ADDRS[i*AW +: AW] == a);
        if (m >= 3'd1 && m <= 3'd4) begin
          if (ue[i]) st[i][b] = ud[i*DW+b];
          else if (wr && h && (m == 3'd1 || m == 3'd4)) st[i][b] = wd[b];
          else if (rd && h && m == 3'd2) st[i][b] = 1'b0;
        end
      end
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; upd_en = '0;
    #1;
    chk({tag, " regs_out"}, regs_out, exp_out());
    chk({tag, " cpu_rdata"}, {{(VW-DW){1'b0}}, cpu_rdata}, {{(VW-DW){1'b0}}, exp_rd});
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NR; i++) st[i] = '0;
    exp_rd = '0;
    #1;
    chk("R1 regs_out after reset", regs_out, exp_out());
    chk("R1 cpu_rdata after reset", {{(VW-DW){1'b0}}, cpu_rdata}, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    live_in = 48'hA5C3_5A3C_96E1;
    // R2 R3 R5 R6 R8: write sweep over all addresses, holes included
    for (int a = 0; a < 32; a++)
      step("R2 R3 R5 R6 R8 write", 1, 0, a[AW-1:0], 8'((a*29+7) & 8'hFF), '0, '0);
    // R2 R3 R4 R5 R6 R7 R8: read sweep
    for (int a = 0; a < 32; a++)
      step("R2 R3 R4 R5 R6 R7 R8 read", 0, 1, a[AW-1:0], '0, '0, '0);
    // R9: logic-side load of every register
    step("R9 update all", 0, 0, '0, '0, 6'h3F, 48'hFFFF_FFFF_FFFF);
    for (int i = 0; i < NR; i++)
      step("R4 R7 R9 read after update", 0, 1, ADDRS[i*AW +: AW], '0, '0, '0);
    step("R4 reread cleared", 0, 1, 5'd3, '0, '0, '0);
    // R10: idle cycles hold read data
    step("R10 hold", 0, 0, 5'd0, '0, '0, '0);
    step("R10 hold write", 1, 0, 5'd0, 8'h11, '0, '0);
    // R9: update beats CPU write and clear-on-read
    step("R9 upd vs write", 1, 0, 5'd0, 8'h0F, 6'h01, 48'h0000_0000_00C6);
    step("R9 upd vs clear", 0, 1, 5'd3, '0, 6'h02, 48'h0000_0000_B700);
    step("R4 R9 read after upd", 0, 1, 5'd3, '0, '0, '0);
    // R7: pass-through follows live input
    live_in = 48'h3C5A_0000_0000;
    step("R7 live read", 0, 1, 5'd16, '0, '0, '0);
    step("R7 R8 live read", 0, 1, 5'd10, '0, '0, '0);
    // R6 R8: write-only read and unused update
    step("R6 wo write", 1, 0, 5'd4, 8'h5E, '0, '0);
    step("R6 wo read", 0, 1, 5'd4, '0, '0, '0);
    step("R8 unused update", 0, 0, '0, '0, 6'h10, 48'h00FF_0000_0000);
    step("R8 unused read", 0, 1, 5'd10, '0, '0, '0);
    // R1: reset in mid run
    do_reset();
    for (int i = 0; i < NR; i++)
      step("R1 R2 read after reset", 0, 1, ADDRS[i*AW +: AW], '0, '0, '0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule